// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Code Loader

This block is the register front end for a pair of 12-bit converter channels. A host with an 8-bit bus fills two staging registers through an active-low chip select and an active-low write strobe. A two-bit address picks which part of a staging register is written: the low byte or the upper nibble. The nibble arrives on the low four bus lines. A separate active-low load strobe, which runs independently of the write strobe, moves both staging words into the two output registers in the same clock. Only the output registers drive the channel codes.

All strobes, the address and the data are brought into the system clock domain through a synchronizer of the same depth, so they stay aligned with each other. The bus has no handshake. A write is accepted in every cycle in which both synchronized strobes are low, so there is no back-pressure, and a ready signal would always be high. The load strobe is level-sensitive. While it is low, the outputs follow the staging registers. When it rises, they keep the last value. A monitor raises a sticky error flag if the load strobe rises fewer than `GUARD_CYCLES` clocks after the end of a write. That case means the load overlapped a write too closely to be trusted.

Top module: `dual_code_loader`

## Requirements
- R1: After a synchronous reset, both channel codes read 0 and the error flag reads 0.
- R2: With chip select and write both low, the address picks the target section: 00 is channel A bits 7..0, 01 is channel A bits 11..8, 10 is channel B bits 7..0 and 11 is channel B bits 11..8. A low-section write takes bus bits 7..0, and a high-section write takes bus bits 3..0.
- R3: While the load strobe is high, writes to the staging registers leave both channel codes unchanged.
- R4: While the load strobe is low, each channel code follows its staging register, including writes made during the low period.
- R5: When the load strobe rises, the codes keep the values they had, and later writes do not alter them.
- R6: A single load updates both channels in the same clock cycle.
- R7: Bus activity with chip select high, or with write high, changes no staging register.
- R8: The sections may be written in any order, and the result depends only on the final value of each section.
- R9: If the synchronized load strobe rises within `GUARD_CYCLES` clocks of the end of a write, the error flag goes high and stays high until reset.
- R10: A load strobe that rises after the guard window has passed leaves the error flag low.
- R11: Asserting reset during operation clears both staging registers, both output registers and the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Section select |
| bus_data | input | 8 | Write data, right-justified |
| ld_n | input | 1 | Load strobe, active low, asynchronous |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| guard_err | output | 1 | Sticky load/write overlap flag |

## Verification
The bench uses each of the four addresses with distinct patterns. A design with a decode error or a high nibble taken from the wrong bus bits would then put values in the wrong channel or the wrong bit positions. It writes with the load strobe high and checks that the codes do not move, which exposes an output register that ignores the double buffering. It then holds the load strobe low across a write and checks that the codes follow, and that they freeze when the strobe rises. It checks writes made with only one strobe low, and it brings the load strobe up both just after a write and well after one. A guard monitor that compares against the wrong window, or that drops the flag once it has been raised, fails one of these two cases.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned HI_W   = CODE_W - BUS_W;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A_LO = 2'b00,
    SEL_A_HI = 2'b01,
    SEL_B_LO = 2'b10,
    SEL_B_HI = 2'b11
  } sect_sel_e;

  typedef struct packed {
    logic [HI_W-1:0]  hi;
    logic [BUS_W-1:0] lo;
  } stage_word_t;
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int unsigned W         = 1,
  parameter int unsigned STAGES    = 2,
  parameter logic [W-1:0] IDLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= IDLE_VAL;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= IDLE_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dcl_input_bank.sv
module dcl_input_bank
  import dcl_pkg::*;
#(
  parameter logic CH_IDX = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  data,
  output logic [CODE_W-1:0] stage_code
);
  stage_word_t stage_q;
  logic        hit;
  logic        hit_lo;
  logic        hit_hi;

  assign hit    = wr_act && (addr[1] == CH_IDX);
  assign hit_lo = hit && !addr[0];
  assign hit_hi = hit &&  addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      if (hit_lo) stage_q.lo <= data;
      if (hit_hi) stage_q.hi <= data[HI_W-1:0];
    end
  end

  assign stage_code = stage_q;

  AST_IDLE_KEEPS_STAGE: assert property (@(posedge clk) disable iff (rst)
    !wr_act |=> $stable(stage_code)) else $error("stage changed without write"); // R7

  AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    (wr_act && addr[0]) |=> $stable(stage_code[BUS_W-1:0])) else $error("low section hit by high write"); // R2
endmodule

// File: rtl/dcl_output_stage.sv
module dcl_output_stage
  import dcl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_act,
  input  logic [CODE_W-1:0] stage_code,
  output logic [CODE_W-1:0] out_code
);
  always_ff @(posedge clk) begin
    if (rst)           out_code <= '0;
    else if (load_act) out_code <= stage_code;
  end

  AST_HOLD_OUTSIDE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_act |=> $stable(out_code)) else $error("output moved with load high"); // R3
endmodule

// File: rtl/dcl_guard.sv
module dcl_guard #(
  parameter int unsigned GUARD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_act,
  input  logic load_act,
  output logic err
);
  localparam int unsigned CNT_W = $clog2(GUARD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GUARD_CYCLES);

  logic [CNT_W-1:0] since_wr;
  logic             load_act_q;
  logic             load_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_wr   <= CNT_MAX;
      load_act_q <= 1'b0;
    end else begin
      load_act_q <= load_act;
      if (wr_act)                since_wr <= '0;
      else if (since_wr < CNT_MAX) since_wr <= since_wr + 1'b1;
    end
  end

  assign load_rise = load_act_q && !load_act;

  always_ff @(posedge clk) begin
    if (rst)                                err <= 1'b0;
    else if (load_rise && since_wr < CNT_MAX) err <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err) else $error("error flag dropped"); // R9

  AST_ERR_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
    (!err && !load_rise) |=> !err) else $error("error without load release"); // R10
endmodule

// File: rtl/dual_code_loader.sv
module dual_code_loader
  import dcl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned GUARD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              ld_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              guard_err
);
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CTL_W  = 3;
  localparam int unsigned PAY_W  = ADDR_W + BUS_W;

  logic [CTL_W-1:0]  ctl_s;
  logic [PAY_W-1:0]  pay_s;
  logic              wr_act;
  logic              load_act;
  logic [ADDR_W-1:0] addr_s;
  logic [BUS_W-1:0]  data_s;
  logic [CODE_W-1:0] stage_code [NUM_CH];
  logic [CODE_W-1:0] out_code   [NUM_CH];

  dcl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .IDLE_VAL({CTL_W{1'b1}})) u_ctl_sync (
    .clk (clk), .rst (rst), .d ({cs_n, wr_n, ld_n}), .q (ctl_s)
  );

  dcl_sync #(.W(PAY_W), .STAGES(SYNC_STAGES), .IDLE_VAL('0)) u_pay_sync (
    .clk (clk), .rst (rst), .d ({addr, bus_data}), .q (pay_s)
  );

  assign wr_act   = !ctl_s[2] && !ctl_s[1];
  assign load_act = !ctl_s[0];
  assign {addr_s, data_s} = pay_s;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dcl_input_bank #(.CH_IDX(c[0])) u_bank (
        .clk (clk), .rst (rst), .wr_act (wr_act), .addr (addr_s),
        .data (data_s), .stage_code (stage_code[c])
      );
      dcl_output_stage u_out (
        .clk (clk), .rst (rst), .load_act (load_act),
        .stage_code (stage_code[c]), .out_code (out_code[c])
      );
    end
  endgenerate

  dcl_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .clk (clk), .rst (rst), .wr_act (wr_act), .load_act (load_act), .err (guard_err)
  );

  assign code_a = out_code[0];
  assign code_b = out_code[1];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (code_a == '0 && code_b == '0 && !guard_err)) else $error("reset incomplete"); // R1

  AST_LOAD_FOLLOWS_A: assert property (@(posedge clk) disable iff (rst)
    load_act |=> code_a == $past(stage_code[0])) else $error("channel A not loaded"); // R4

  AST_LOAD_FOLLOWS_B: assert property (@(posedge clk) disable iff (rst)
    load_act |=> code_b == $past(stage_code[1])) else $error("channel B not loaded"); // R6
endmodule

// File: tb/test_dual_code_loader.sv
module test_dual_code_loader;
  localparam time CLK_PERIOD = 10ns;
  localparam int  GUARD      = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  bus_data = '0;
  logic        ld_n = 1'b1;
  logic [11:0] code_a;
  logic [11:0] code_b;
  logic        guard_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_code_loader #(.SYNC_STAGES(2), .GUARD_CYCLES(GUARD)) i_dual_code_loader (
    .clk (clk), .rst (rst), .cs_n (cs_n), .wr_n (wr_n), .addr (addr),
    .bus_data (bus_data), .ld_n (ld_n), .code_a (code_a), .code_b (code_b),
    .guard_err (guard_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                           input logic use_cs = 1'b1, input logic use_wr = 1'b1);
    @(negedge clk);
    addr = a; bus_data = d;
    cs_n = !use_cs; wr_n = !use_wr;
    idle(3);
    cs_n = 1'b1; wr_n = 1'b1;
    idle(2);
  endtask

  task automatic load_pulse();
    @(negedge clk);
    ld_n = 1'b0;
    idle(3);
    ld_n = 1'b1;
    idle(8);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 code_a", code_a, 0);
    chk("R1 code_b", code_b, 0);
    chk("R1 err", guard_err, 0);
  endtask

  task automatic t_stage_and_load();
    bus_write(2'b00, 8'hA5);
    bus_write(2'b01, 8'hF3);
    bus_write(2'b10, 8'h3C);
    bus_write(2'b11, 8'h09);
    idle(GUARD + 6);
    chk("R3 code_a held", code_a, 0);
    chk("R3 code_b held", code_b, 0);
    load_pulse();
    chk("R2 code_a", code_a, 'h3A5);
    chk("R6 code_b", code_b, 'h93C);
    chk("R10 no err", guard_err, 0);
  endtask

  task automatic t_hold_after_load();
    bus_write(2'b00, 8'h11);
    bus_write(2'b11, 8'h0E);
    idle(6);
    chk("R5 code_a kept", code_a, 'h3A5);
    chk("R5 code_b kept", code_b, 'h93C);
  endtask

  task automatic t_transparent();
    @(negedge clk);
    ld_n = 1'b0;
    idle(6);
    chk("R4 code_a follows", code_a, 'h311);
    chk("R4 code_b follows", code_b, 'hE3C);
    bus_write(2'b10, 8'h77);
    idle(4);
    chk("R4 write during load", code_b, 'hE77);
    idle(GUARD + 6);
    ld_n = 1'b1;
    idle(6);
    bus_write(2'b10, 8'h00);
    idle(4);
    chk("R5 frozen after rise", code_b, 'hE77);
    chk("R10 late rise no err", guard_err, 0);
  endtask

  task automatic t_order();
    bus_write(2'b01, 8'h05);
    bus_write(2'b11, 8'h0A);
    bus_write(2'b10, 8'hBE);
    bus_write(2'b00, 8'hEF);
    bus_write(2'b00, 8'h42);
    idle(GUARD + 6);
    load_pulse();
    chk("R8 code_a", code_a, 'h542);
    chk("R8 code_b", code_b, 'hABE);
  endtask

  task automatic t_ignored();
    bus_write(2'b00, 8'hFF, 1'b0, 1'b1);
    bus_write(2'b10, 8'hFF, 1'b1, 1'b0);
    idle(GUARD + 6);
    load_pulse();
    chk("R7 code_a", code_a, 'h542);
    chk("R7 code_b", code_b, 'hABE);
    chk("R10 err", guard_err, 0);
  endtask

  task automatic t_guard();
    @(negedge clk);
    ld_n = 1'b0;
    idle(6);
    addr = 2'b00; bus_data = 8'h99;
    cs_n = 1'b0; wr_n = 1'b0;
    idle(3);
    cs_n = 1'b1; wr_n = 1'b1;
    idle(1);
    ld_n = 1'b1;
    idle(8);
    chk("R9 err raised", guard_err, 1);
    chk("R9 code_a", code_a, 'h599);
    idle(GUARD + 10);
    chk("R9 err sticky", guard_err, 1);
  endtask

  task automatic t_midreset();
    do_reset();
    chk("R11 err", guard_err, 0);
    chk("R11 code_a", code_a, 0);
    load_pulse();
    chk("R11 stage_a cleared", code_a, 0);
    chk("R11 stage_b cleared", code_b, 0);
  endtask

  initial begin
    t_reset();
    t_stage_and_load();
    t_hold_after_load();
    t_transparent();
    t_order();
    t_ignored();
    t_guard();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule